// File: doc/BRIEF.md
# Multi-Channel Snapshot Capture Packetizer

This block takes a one-shot, time-domain snapshot of several parallel converter sample streams and then sends the stored data out as a train of byte-wide packets. Software picks a subset of the channels with a mask and issues an arm command. On every valid sample cycle after that, the block keeps only the upper byte of each selected channel's word and writes these bytes into an on-chip buffer. They go in packed form, lowest channel index first, and unselected channels take no room. Once the buffer holds as many whole frames as fit, capture stops and readout begins. Capture and readout never overlap.

Readout splits the stored bytes into packets of a fixed payload size, and the last packet may be shorter. Each packet starts with a header that carries:
- a 16-bit packet sequence number,
- first-packet and last-packet flags,
- the payload length,
- the captured channel mask, so that a receiver can separate the interleaved channels.

The output is a ready/valid byte stream with start and end markers, and it tolerates any pattern of back-pressure. When the final packet has been taken, the block returns to idle and raises a done flag.

Top module: `snap_pktzr`

## Requirements
- R1: An arm pulse while idle with a nonzero `chan_mask` starts a capture (`busy` high on the next cycle, `arm_err` low). The mask is sampled only in that cycle, so later changes of `chan_mask` have no effect on the capture.
- R2: An arm pulse while idle with an all-zero mask sets `arm_err`, and `busy` stays low.
- R3: An arm pulse while a capture or a readout is in progress is ignored. The packet stream, including its total length and header mask, is the same as without it.
- R4: Let k be the number of mask bits set. Each sample cycle with `smp_valid` high stores the upper 8 bits of every enabled channel's word, in ascending channel order. Exactly floor(NCH*ROWS/k) frames are stored, and the payload bytes across all packets, taken in order, are exactly those frames one after another.
- R5: `out_valid` stays low for the whole capture. Readout starts only after the last frame has been written.
- R6: Every packet starts with a header of 4+ceil(NCH/8) bytes in this order: sequence high byte, sequence low byte, flags (bit 7 = first packet, bit 6 = last packet, other bits 0), payload length, then the mask bytes with mask bits 7..0 in the first of them.
- R7: Every packet except the last carries PAYLOAD payload bytes. The last carries the remainder (1..PAYLOAD), and the header length byte matches.
- R8: The sequence number is 0 in the first packet after an arm and increases by one per packet, wrapping modulo 2^16.
- R9: `out_sop` is high only on the first header byte of a packet, and `out_eop` is high only on its last payload byte.
- R10: While `out_valid` is high and `out_ready` is low, `out_data`, `out_sop` and `out_eop` hold their values. No byte is lost or repeated.
- R11: After the last byte of the last packet is accepted, `busy` falls and `done` is high. The next accepted arm clears `done`.
- R12: After reset the block is idle: `out_valid`, `busy`, `done` and `arm_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Common strobe: all channel words are valid this cycle |
| smp_data | input | NCH*SW | Channel words; channel c occupies bits c*SW +: SW |
| chan_mask | input | NCH | Channel select, bit c enables channel c |
| arm | input | 1 | Start command, one cycle |
| out_ready | input | 1 | Downstream can accept a byte |
| out_data | output | 8 | Stream byte |
| out_valid | output | 1 | `out_data` is valid |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| busy | output | 1 | Capture or readout in progress |
| done | output | 1 | Last snapshot fully sent |
| arm_err | output | 1 | Last idle arm had an empty mask |

## Verification
The bench sweeps every channel mask of a four-channel configuration and uses an irregular ready pattern and gapped sample strobes throughout.

Each sweep point covers a set of corner cases, and each corner case catches a particular kind of faulty design:
- **Channel packing.** A design that packed channels in the wrong order, or reserved slots for disabled channels, would put payload bytes in the wrong places or end the stream early.
- **Partial last packet.** Sweeping all masks makes the total byte count fall both on and off a payload boundary. A design that mishandled the short final packet would give the wrong length byte, lose the last flag or drop the remaining bytes.
- **Stray arm commands.** The bench issues arm pulses in the middle of capture and of readout. A design that accepted them would restart the sequence number or change the mask byte and the stream length.
- **Stalled output.** A design that let its output move during a stall would show up as a changed held byte or a skipped or duplicated byte in the reassembled stream.

// File: rtl/snap_pkg.sv
package snap_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_CAP   = 2'd1,
    S_DRAIN = 2'd2,
    S_FLUSH = 2'd3
  } snap_state_e;

  function automatic int unsigned ones(input logic [63:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/snap_lane_ram.sv
module snap_lane_ram #(
  parameter int ROWS = 16,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [RW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/snap_frame_pack.sv
module snap_frame_pack #(
  parameter int NCH = 16,
  parameter int SW  = 14,
  localparam int LW = $clog2(NCH)
) (
  input  logic [NCH*SW-1:0] smp_data,
  input  logic [NCH-1:0]    mask,
  input  logic [LW:0]       k,
  input  logic [LW-1:0]     base,
  output logic [NCH-1:0]    lane_we,
  output logic [NCH*8-1:0]  lane_wd
);

  logic [7:0] comp [NCH];
  logic [LW:0] n;

  // compact enabled channels, lowest index first
  always_comb begin
    n = '0;
    for (int c = 0; c < NCH; c++) comp[c] = '0;
    for (int c = 0; c < NCH; c++) begin
      if (mask[c]) begin
        comp[n[LW-1:0]] = smp_data[c*SW+SW-8 +: 8];
        n = n + 1'b1;
      end
    end
  end

  // rotate the compacted frame onto lanes starting at the write base
  for (genvar L = 0; L < NCH; L++) begin : g_lane
    logic [LW-1:0] rel;
    assign rel = LW'(L) - base;
    assign lane_we[L] = {1'b0, rel} < k;
    assign lane_wd[L*8 +: 8] = comp[rel];
  end

endmodule

// File: rtl/snap_pktzr.sv
module snap_pktzr
  import snap_pkg::*;
#(
  parameter int NCH     = 16,
  parameter int SW      = 14,
  parameter int ROWS    = 16,
  parameter int PAYLOAD = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [NCH*SW-1:0] smp_data,
  input  logic [NCH-1:0]    chan_mask,
  input  logic              arm,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic              busy,
  output logic              done,
  output logic              arm_err
);

  localparam int LW    = $clog2(NCH);
  localparam int RW    = $clog2(ROWS);
  localparam int AW    = LW + RW + 1;
  localparam int DEPTH = NCH * ROWS;
  localparam int MB    = (NCH + 7) / 8;
  localparam int HDR   = 4 + MB;
  localparam int IW    = $clog2(HDR + PAYLOAD + 1);

  snap_state_e     state;
  logic [NCH-1:0]  mask_q;
  logic [LW:0]     k_q;
  logic [AW-1:0]   fill_q, wptr, rd_ptr, rd_nxt, rem;
  logic [15:0]     seq;
  logic [IW-1:0]   idx;
  logic [7:0]      plen, len_c, pay_byte;
  logic            plast, pfirst, last_c;
  logic            adv, cap_go, pay_step;
  logic [LW-1:0]   wbase;
  logic [RW-1:0]   wrow, rrow;
  logic [NCH-1:0]  lane_we;
  logic [NCH*8-1:0] lane_wd, lane_q;
  logic [MB*8-1:0] mask_pad;
  int unsigned     arm_k;

  assign busy     = (state != S_IDLE);
  assign adv      = !out_valid || out_ready;
  assign cap_go   = (state == S_CAP) && smp_valid;
  assign wbase    = wptr[LW-1:0];
  assign wrow     = wptr[LW+RW-1:LW];
  assign pay_step = (state == S_DRAIN) && adv && (idx >= IW'(HDR));
  assign rd_nxt   = rd_ptr + AW'(pay_step);
  assign rrow     = rd_nxt[LW+RW-1:LW];
  assign rem      = fill_q - rd_ptr;
  assign len_c    = (int'(rem) >= PAYLOAD) ? 8'(PAYLOAD) : 8'(rem);
  assign last_c   = int'(rem) <= PAYLOAD;
  assign mask_pad = (MB*8)'(mask_q);
  assign arm_k    = ones(64'(chan_mask));
  assign pay_byte = lane_q[8*rd_ptr[LW-1:0] +: 8];

  snap_frame_pack #(.NCH(NCH), .SW(SW)) pack_i (
    .smp_data (smp_data),
    .mask     (mask_q),
    .k        (k_q),
    .base     (wbase),
    .lane_we  (lane_we),
    .lane_wd  (lane_wd)
  );

  for (genvar L = 0; L < NCH; L++) begin : g_ram
    logic [RW-1:0] row;
    assign row = (LW'(L) >= wbase) ? wrow : wrow + 1'b1;
    snap_lane_ram #(.ROWS(ROWS)) ram_i (
      .clk   (clk),
      .we    (cap_go && lane_we[L]),
      .waddr (row),
      .wdata (lane_wd[L*8 +: 8]),
      .raddr (rrow),
      .rdata (lane_q[L*8 +: 8])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      mask_q    <= '0;
      k_q       <= '0;
      fill_q    <= '0;
      wptr      <= '0;
      rd_ptr    <= '0;
      seq       <= '0;
      idx       <= '0;
      plen      <= '0;
      plast     <= 1'b0;
      pfirst    <= 1'b0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      done      <= 1'b0;
      arm_err   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (arm) begin
            if (chan_mask == '0) begin
              arm_err <= 1'b1;
            end else begin
              arm_err <= 1'b0;
              done    <= 1'b0;
              mask_q  <= chan_mask;
              k_q     <= (LW+1)'(arm_k);
              fill_q  <= AW'((DEPTH / arm_k) * arm_k);
              wptr    <= '0;
              rd_ptr  <= '0;
              seq     <= '0;
              idx     <= '0;
              pfirst  <= 1'b1;
              state   <= S_CAP;
            end
          end
        end
        S_CAP: begin
          if (smp_valid) begin
            wptr <= wptr + AW'(k_q);
            if (wptr + AW'(k_q) == fill_q) state <= S_DRAIN;
          end
        end
        S_DRAIN: begin
          if (adv) begin
            out_valid <= 1'b1;
            out_sop   <= (idx == '0);
            out_eop   <= 1'b0;
            idx       <= idx + 1'b1;
            if (idx == IW'(0)) begin
              out_data <= seq[15:8];
              plen     <= len_c;
              plast    <= last_c;
            end else if (idx == IW'(1)) begin
              out_data <= seq[7:0];
            end else if (idx == IW'(2)) begin
              out_data <= {pfirst, plast, 6'b0};
            end else if (idx == IW'(3)) begin
              out_data <= plen;
            end else if (idx < IW'(HDR)) begin
              out_data <= mask_pad[8*(int'(idx)-4) +: 8];
            end else begin
              out_data <= pay_byte;
              rd_ptr   <= rd_nxt;
              if (idx == IW'(HDR) + IW'(plen) - 1'b1) begin
                out_eop <= 1'b1;
                idx     <= '0;
                seq     <= seq + 1'b1;
                pfirst  <= 1'b0;
                if (plast) state <= S_FLUSH;
              end
            end
          end
        end
        S_FLUSH: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            done      <= 1'b1;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10: a stalled byte and its markers stay put
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

  // R5: nothing leaves while the buffer is filling
  p_quiet_cap_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_CAP) |-> !out_valid);

  // R2: empty mask flags an error and leaves the block idle
  p_bad_arm_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && arm && chan_mask == '0) |=> (arm_err && !busy));

  // R3: arm while busy changes neither the captured mask nor the error flag
  p_busy_arm_r3: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE && arm) |=> ($stable(mask_q) && $stable(arm_err)));

  // R8: sequence steps by one when a packet's end is emitted
  p_seq_step_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(out_eop) |-> (seq == $past(seq) + 16'd1));

  // R11: leaving busy always reports completion
  p_done_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R4: each valid frame writes exactly one byte per enabled channel
  p_lane_cnt_r4: assert property (@(posedge clk) disable iff (rst)
    cap_go |-> ($countones(lane_we) == int'(k_q)));

  // R7: readout never walks past the filled region
  p_rd_bound_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rd_ptr <= fill_q));

endmodule

// File: tb/snap_pktzr_tb_top.sv
`timescale 1ns/1ps
module snap_pktzr_tb_top;

  localparam int NCH = 4, SW = 10, ROWS = 8, PAY = 6;
  localparam int DEPTH = NCH * ROWS, HDR = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic [NCH*SW-1:0] smp_data = '0;
  logic [NCH-1:0] chan_mask = '0;
  logic arm = 1'b0;
  logic out_ready = 1'b0;
  logic [7:0] out_data;
  logic out_valid, out_sop, out_eop, busy, done, arm_err;

  snap_pktzr #(.NCH(NCH), .SW(SW), .ROWS(ROWS), .PAYLOAD(PAY)) dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .chan_mask(chan_mask), .arm(arm), .out_ready(out_ready),
    .out_data(out_data), .out_valid(out_valid), .out_sop(out_sop),
    .out_eop(out_eop), .busy(busy), .done(done), .arm_err(arm_err)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  function automatic logic [7:0] sbyte(int f, int c, int m);
    return 8'(f * 37 + c * 64 + m * 5 + 1);
  endfunction

  function automatic int nth(int m, int r);
    int n = 0;
    for (int c = 0; c < NCH; c++) begin
      if (m[c]) begin
        if (n == r) return c;
        n++;
      end
    end
    return 0;
  endfunction

  // ready pattern, changed away from the active edge
  int rcyc = 0;
  always @(negedge clk) begin
    rcyc++;
    out_ready <= (rcyc % 5 != 2) && (rcyc % 7 != 3);
  end

  // recorder and stall check
  logic [7:0] rec_d [512];
  bit rec_s [512], rec_e [512];
  int rec_n = 0;
  bit held = 0;
  logic [7:0] h_d;
  bit h_s, h_e;
  always @(negedge clk) begin
    #1;
    if (held) begin
      chk(out_valid && out_data == h_d && out_sop == h_s && out_eop == h_e,
          "R10 held byte", int'(out_data), int'(h_d));
    end
    held = out_valid && !out_ready;
    h_d = out_data; h_s = out_sop; h_e = out_eop;
    if (out_valid && out_ready && rec_n < 512) begin
      rec_d[rec_n] = out_data;
      rec_s[rec_n] = out_sop;
      rec_e[rec_n] = out_eop;
      rec_n++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(!out_valid && !busy && !done && !arm_err, "R12 reset state",
        int'({out_valid, busy, done, arm_err}), 0);

    for (int m = 0; m < 16; m++) begin
      int k, nf, fr, cyc, tot, np, pos, pay;
      rec_n = 0;
      chan_mask = 4'(m);
      arm = 1'b1;
      @(negedge clk); #1;
      arm = 1'b0;
      chan_mask = ~4'(m);
      if (m == 0) begin
        chk(arm_err == 1'b1, "R2 empty mask error", int'(arm_err), 1);
        chk(busy == 1'b0, "R2 empty mask stays idle", int'(busy), 0);
        continue;
      end
      chk(busy == 1'b1, "R1 arm starts capture", int'(busy), 1);
      chk(arm_err == 1'b0, "R1 error cleared", int'(arm_err), 0);
      chk(done == 1'b0, "R11 done cleared by arm", int'(done), 0);

      k = 0;
      for (int c = 0; c < NCH; c++) k += m[c];
      nf = DEPTH / k;
      fr = 0; cyc = 0;
      while (fr < nf + 2) begin
        smp_valid = (cyc % 3 != 1);
        if (smp_valid) begin
          for (int c = 0; c < NCH; c++)
            smp_data[c*SW +: SW] = {sbyte(fr, c, m), 2'(fr + c)};
          fr++;
        end
        arm = (cyc == 4);   // R3: stray arm during capture
        cyc++;
        @(negedge clk); #1;
        if (fr < nf) chk(!out_valid, "R5 no output during capture", int'(out_valid), 0);
      end
      smp_valid = 1'b0;
      arm = 1'b1;           // R3: stray arm during readout
      @(negedge clk); #1;
      arm = 1'b0;
      while (busy) begin @(negedge clk); #1; end
      repeat (2) @(negedge clk);
      #1;
      chk(done == 1'b1 && busy == 1'b0, "R11 done after last packet",
          int'({done, busy}), 2);

      tot = nf * k;
      np = (tot + PAY - 1) / PAY;
      pos = 0; pay = 0;
      for (int p = 0; p < np; p++) begin
        int len;
        bit last;
        logic [7:0] hx [HDR];
        len = (tot - p * PAY < PAY) ? tot - p * PAY : PAY;
        last = (p == np - 1);
        hx[0] = 8'(p >> 8);
        hx[1] = 8'(p);
        hx[2] = {p == 0, last, 6'b0};
        hx[3] = 8'(len);
        hx[4] = 8'(m);
        for (int i = 0; i < HDR; i++) begin
          if (i < 2)
            chk(rec_d[pos] == hx[i], "R8 sequence byte", int'(rec_d[pos]), int'(hx[i]));
          else if (i == 3)
            chk(rec_d[pos] == hx[i], "R7 length byte", int'(rec_d[pos]), int'(hx[i]));
          else
            chk(rec_d[pos] == hx[i], "R6 header byte", int'(rec_d[pos]), int'(hx[i]));
          chk(rec_s[pos] == (i == 0) && !rec_e[pos], "R9 header markers",
              int'({rec_s[pos], rec_e[pos]}), (i == 0) ? 2 : 0);
          pos++;
        end
        for (int j = 0; j < len; j++) begin
          int b, f, c;
          logic [7:0] ex;
          b = pay + j;
          f = b / k;
          c = nth(m, b % k);
          ex = sbyte(f, c, m);
          chk(rec_d[pos] == ex, "R4 payload byte", int'(rec_d[pos]), int'(ex));
          chk(!rec_s[pos] && rec_e[pos] == (j == len - 1), "R9 payload markers",
              int'({rec_s[pos], rec_e[pos]}), (j == len - 1) ? 1 : 0);
          pos++;
        end
        pay += len;
      end
      chk(rec_n == pos, "R4 total stream length", rec_n, pos);
    end

    report();
    $finish;
  end

endmodule